// File: doc/BRIEF.md
# Full-Map Home Directory Coherence Controller

This block is the home directory for a group of processors that share memory through write-back caches kept coherent by write invalidation. Each memory block it owns has one directory entry: a bit vector with one bit per processor that marks which caches hold a copy, and a dirty flag. When the flag is set, a single processor owns the block and its cache holds the only current data.

A miss arrives on the request port as a read or a write, tagged with the requesting processor's index and the block index. The controller reads the entry and chooses one of four action sequences, depending on the miss type and the dirty flag. It issues recall, invalidate and data-supply messages on a valid/ready message port. It collects invalidation acknowledgements and recalled data on an acknowledgement input, writes recalled data back into its small memory array, and then updates the entry. Only one transaction is in flight at any time, and new requests are held off until the current one completes.

Top module: `dirHome`

## Requirements
- R1: After reset every entry has no presence bits set and a clear dirty flag, and the memory array holds zero, so a first read miss to any block gets a supply of zero with no recall or invalidation before it. reqReady is 1 and msgValid is 0 right after reset.
- R2: Whenever the dirty flag of an entry is set, exactly one presence bit of that entry is set. That processor is the owner and is the destination of any recall for the block.
- R3: A read miss by processor i to a clean block is answered by a single supply message (msgKind 0) to i, carrying the memory word. Presence bit i is then set and the other bits are kept.
- R4: A read miss by processor i to a dirty block first sends a shared-recall (msgKind 1) to the owner. The data returned on the acknowledgement port is written to memory and supplied to i. The dirty flag is then cleared and both the former owner and i are marked present.
- R5: A write miss by processor i to a clean block sends one invalidate (msgKind 3) to every present processor other than i, lowest index first, and never to i. After the supply, i is the only processor present and the dirty flag is set.
- R6: A write miss by processor i to a dirty block sends an invalidating recall (msgKind 2) to the owner, writes the returned data to memory and supplies it to i. After that, i is the sole present processor and the dirty flag stays set.
- R7: The supply for a write miss is not offered until every invalidation sent has been acknowledged. An acknowledgement that arrives in the same cycle as the handshake of a later invalidate is counted.
- R8: reqReady stays low from the cycle a request is accepted until its supply message has been accepted, so other requests are held.
- R9: While msgValid is high and msgReady is low, msgValid stays high and msgKind, msgDest, msgAddr and msgData do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Directory idle and taking a request |
| reqWrite | input | 1 | 1 for write miss, 0 for read miss |
| reqProc | input | PROC_W | Requesting processor index |
| reqAddr | input | ADDR_W | Block index |
| msgValid | output | 1 | Outgoing message present |
| msgReady | input | 1 | Network takes the message |
| msgKind | output | 2 | 0 supply, 1 shared recall, 2 invalidating recall, 3 invalidate |
| msgDest | output | PROC_W | Destination processor |
| msgAddr | output | ADDR_W | Block the message refers to |
| msgData | output | DATA_W | Supplied data (valid for kind 0) |
| ackValid | input | 1 | One acknowledgement or recall reply |
| ackData | input | DATA_W | Data returned by a recall |

## Verification
Two things can fall in the same cycle: the handshake of one invalidate and the acknowledgement of an earlier one. In that cycle the outstanding count must both rise and fall. The bench drives acknowledgements at random against a random msgReady, so during write misses to blocks with several sharers the two events often coincide. A reference model in the bench counts outstanding acknowledgements and marks an error if the supply appears while any of them is still unanswered. Every message is also compared with the sequence the bench model predicts from its own copy of the directory.

// File: rtl/dirPkg.sv
package dirPkg;
  typedef enum logic [1:0] {
    MSG_SUPPLY     = 2'd0,
    MSG_RECALL_SHR = 2'd1,
    MSG_RECALL_INV = 2'd2,
    MSG_INVAL      = 2'd3
  } msgKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic writeBack;
    logic invSent;
    logic ackTaken;
    logic commit;
  } strobes_t;
endpackage

// File: rtl/dirDatapath.sv
module dirDatapath import dirPkg::*; #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 32,
  parameter int PROC_W     = $clog2(NUM_PROCS),
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  msgKind_e          kind,
  input  logic              reqWrite,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] ackData,
  output logic              dirtyHit,
  output logic              isWrite,
  output logic              pendEmpty,
  output logic              pendLast,
  output logic              ackZero,
  output logic [PROC_W-1:0] msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);
  localparam int CNT_W = PROC_W + 1;

  logic [NUM_PROCS-1:0] presReg [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] dirtyReg;
  logic [DATA_W-1:0]    memReg  [NUM_BLOCKS];
  logic [ADDR_W-1:0]    addrQ;
  logic [PROC_W-1:0]    procQ;
  logic                 writeQ;
  logic [NUM_PROCS-1:0] pendMask;
  logic [CNT_W-1:0]     ackCnt;

  function automatic logic [PROC_W-1:0] lowIdx(input logic [NUM_PROCS-1:0] v);
    lowIdx = '0;
    for (int k = NUM_PROCS - 1; k >= 0; k--)
      if (v[k]) lowIdx = k[PROC_W-1:0];
  endfunction

  function automatic logic [NUM_PROCS-1:0] oneHot(input logic [PROC_W-1:0] p);
    oneHot = '0;
    oneHot[p] = 1'b1;
  endfunction

  assign dirtyHit  = dirtyReg[addrQ];
  assign isWrite   = writeQ;
  assign pendEmpty = (pendMask == '0);
  assign pendLast  = ((pendMask & (pendMask - 1'b1)) == '0);
  assign ackZero   = (ackCnt == '0);
  assign msgAddr   = addrQ;
  assign msgData   = memReg[addrQ];

  always_comb begin
    unique case (kind)
      MSG_RECALL_SHR, MSG_RECALL_INV: msgDest = lowIdx(presReg[addrQ]);
      MSG_INVAL:                      msgDest = lowIdx(pendMask);
      default:                        msgDest = procQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      procQ    <= '0;
      writeQ   <= 1'b0;
      pendMask <= '0;
      ackCnt   <= '0;
    end else begin
      if (stb.latchReq) begin
        addrQ  <= reqAddr;
        procQ  <= reqProc;
        writeQ <= reqWrite;
        pendMask <= (reqWrite && !dirtyReg[reqAddr]) ?
                    (presReg[reqAddr] & ~oneHot(reqProc)) : '0;
      end else if (stb.invSent) begin
        pendMask <= pendMask & (pendMask - 1'b1);
      end
      ackCnt <= ackCnt + CNT_W'(stb.invSent) - CNT_W'(stb.ackTaken);
    end
  end

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          presReg[b]  <= '0;
          dirtyReg[b] <= 1'b0;
          memReg[b]   <= '0;
        end else if (addrQ == ADDR_W'(b)) begin
          if (stb.writeBack) memReg[b] <= ackData;
          if (stb.commit) begin
            presReg[b]  <= writeQ ? oneHot(procQ) : (presReg[b] | oneHot(procQ));
            dirtyReg[b] <= writeQ;
          end
        end
      end

      p_single_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
        dirtyReg[b] |-> $onehot(presReg[b]));
    end
  endgenerate

  p_ack_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackTaken && !stb.invSent) |-> (ackCnt != '0));
endmodule

// File: rtl/dirControl.sv
module dirControl import dirPkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     msgValid,
  input  logic     msgReady,
  output msgKind_e kind,
  input  logic     ackValid,
  input  logic     dirtyHit,
  input  logic     isWrite,
  input  logic     pendEmpty,
  input  logic     pendLast,
  input  logic     ackZero,
  output strobes_t stb
);
  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_RECALL_SEND, S_RECALL_WAIT, S_INV_SEND, S_INV_WAIT, S_SUPPLY
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    reqReady  = 1'b0;
    msgValid  = 1'b0;
    kind      = MSG_SUPPLY;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (dirtyHit)                   stateNext = S_RECALL_SEND;
        else if (isWrite && !pendEmpty) stateNext = S_INV_SEND;
        else                            stateNext = S_SUPPLY;
      end
      S_RECALL_SEND: begin
        msgValid = 1'b1;
        kind     = isWrite ? MSG_RECALL_INV : MSG_RECALL_SHR;
        if (msgReady) stateNext = S_RECALL_WAIT;
      end
      S_RECALL_WAIT: begin
        if (ackValid) begin
          stb.writeBack = 1'b1;
          stateNext     = S_SUPPLY;
        end
      end
      S_INV_SEND: begin
        msgValid     = 1'b1;
        kind         = MSG_INVAL;
        stb.ackTaken = ackValid;
        if (msgReady) begin
          stb.invSent = 1'b1;
          if (pendLast) stateNext = S_INV_WAIT;
        end
      end
      S_INV_WAIT: begin
        stb.ackTaken = ackValid;
        if (ackZero) stateNext = S_SUPPLY;
      end
      default: begin
        msgValid = 1'b1;
        kind     = MSG_SUPPLY;
        if (msgReady) begin
          stb.commit = 1'b1;
          stateNext  = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  p_recall_then_supply_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RECALL_WAIT && ackValid) |=> (state == S_SUPPLY));

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid) |=> !reqReady);
endmodule

// File: rtl/dirHome.sv
module dirHome import dirPkg::*; #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 32,
  localparam int PROC_W    = $clog2(NUM_PROCS),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [1:0]        msgKind,
  output logic [PROC_W-1:0] msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData,
  input  logic              ackValid,
  input  logic [DATA_W-1:0] ackData
);
  strobes_t stb;
  msgKind_e kind;
  logic dirtyHit, isWrite, pendEmpty, pendLast, ackZero;

  dirControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .msgValid(msgValid), .msgReady(msgReady), .kind(kind), .ackValid(ackValid),
    .dirtyHit(dirtyHit), .isWrite(isWrite), .pendEmpty(pendEmpty),
    .pendLast(pendLast), .ackZero(ackZero), .stb(stb)
  );

  dirDatapath #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .kind(kind), .reqWrite(reqWrite),
    .reqProc(reqProc), .reqAddr(reqAddr), .ackData(ackData),
    .dirtyHit(dirtyHit), .isWrite(isWrite), .pendEmpty(pendEmpty),
    .pendLast(pendLast), .ackZero(ackZero), .msgDest(msgDest),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  assign msgKind = kind;

  p_supply_after_acks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && kind == MSG_SUPPLY) |-> ackZero);

  p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgKind) && $stable(msgDest)
                                  && $stable(msgAddr) && $stable(msgData)));
endmodule

// File: tb/tb_dirHome.sv
module tb_dirHome;
  localparam int NP = 4, NB = 8, DW = 32;
  localparam int PW = $clog2(NP), AW = $clog2(NB);

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, msgReady = 0, ackValid = 0;
  logic [PW-1:0] reqProc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] ackData = '0;
  logic reqReady, msgValid;
  logic [1:0] msgKind;
  logic [PW-1:0] msgDest;
  logic [AW-1:0] msgAddr;
  logic [DW-1:0] msgData;

  dirHome #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) dut (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;

  bit [NP-1:0] mPres [NB];
  bit          mDirty[NB];
  logic [DW-1:0] mMem[NB];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ownerOf(input bit [NP-1:0] v);
    for (int k = 0; k < NP; k++) if (v[k]) return k;
    return 0;
  endfunction

  task automatic runTxn(input bit w, input int p, input int a);
    int expKind[NP+1];
    int expDest[NP+1];
    int expLen = 0, idx = 0, pend = 0;
    bit done = 0, recallOut = 0, held = 0, r8ok = 1;
    logic [DW-1:0] supplyData = mMem[a];
    logic [1:0] hKind; logic [PW-1:0] hDest; logic [DW-1:0] hData;
    if (mDirty[a]) begin
      expKind[0] = w ? 2 : 1; expDest[0] = ownerOf(mPres[a]); expLen = 1;
    end else if (w) begin
      for (int j = 0; j < NP; j++)
        if (mPres[a][j] && j != p) begin
          expKind[expLen] = 3; expDest[expLen] = j; expLen++;
        end
    end
    expKind[expLen] = 0; expDest[expLen] = p; expLen++;

    @(negedge clk);
    reqValid = 1; reqWrite = w; reqProc = PW'(p); reqAddr = AW'(a);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!done) begin
      if (reqReady) r8ok = 0;
      if (held) begin  // R9 stability
        chk(msgValid && msgKind == hKind && msgDest == hDest && msgData == hData,
            "R9 held message", {msgKind, msgDest}, {hKind, hDest});
      end
      ackValid = (pend > 0) && ($urandom % 2 == 1);
      if (ackValid) begin
        pend--;
        ackData = $urandom;
        if (recallOut) begin supplyData = ackData; recallOut = 0; end
      end
      msgReady = ($urandom % 3 != 0);
      held = msgValid && !msgReady;
      hKind = msgKind; hDest = msgDest; hData = msgData;
      if (msgValid && msgReady) begin
        if (idx >= expLen) begin
          chk(0, "R3 extra message", msgKind, 0);
        end else begin
          case (expKind[idx])
            0: begin
              chk(msgKind == 0 && msgDest == PW'(p), "R3 supply kind/dest", {msgKind, msgDest}, {2'd0, PW'(p)});
              chk(msgData == supplyData, "R4_R6 supply data", msgData, supplyData);
              chk(pend == 0, "R7 supply before all acks", pend, 0);
              done = 1;
            end
            1: chk(msgKind == 1 && msgDest == PW'(expDest[idx]), "R4 R2 shared recall", {msgKind, msgDest}, {2'd1, PW'(expDest[idx])});
            2: chk(msgKind == 2 && msgDest == PW'(expDest[idx]), "R6 R2 invalidating recall", {msgKind, msgDest}, {2'd2, PW'(expDest[idx])});
            default: chk(msgKind == 3 && msgDest == PW'(expDest[idx]), "R5 invalidate", {msgKind, msgDest}, {2'd3, PW'(expDest[idx])});
          endcase
          if (expKind[idx] == 1 || expKind[idx] == 2) recallOut = 1;
          if (expKind[idx] != 0) pend++;
          chk(msgAddr == AW'(a), "R3 message block", msgAddr, a);
        end
        idx++;
        held = 0;
      end
      @(negedge clk);
    end
    msgReady = 0; ackValid = 0;
    chk(r8ok, "R8 request held off", r8ok, 1);
    if (mDirty[a]) mMem[a] = supplyData;
    if (w) begin mPres[a] = '0; mPres[a][p] = 1; mDirty[a] = 1; end
    else begin mPres[a][p] = 1; mDirty[a] = 0; end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        nFails++; nChecks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin mPres[b] = '0; mDirty[b] = 0; mMem[b] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1 && msgValid == 0, "R1 reset outputs", {reqReady, msgValid}, 2'b10);
    runTxn(0, 1, 0);  // R1 R3 clean first read
    runTxn(0, 2, 0);  // R3 second sharer
    runTxn(1, 1, 0);  // R5 requester is a sharer
    runTxn(0, 3, 0);  // R4 read of dirty block
    runTxn(1, 0, 0);  // R5 two sharers
    runTxn(1, 2, 0);  // R6 write of dirty block
    runTxn(1, 2, 0);  // R6 owner rewrites
    runTxn(0, 0, 5);  // R1 untouched block
    for (int p = 0; p < NP; p++) runTxn(0, p, 3);
    runTxn(1, 1, 3);  // R7 three invalidations, overlapping acks
    for (int n = 0; n < 400; n++)
      runTxn($urandom % 2, $urandom % NP, $urandom % 4);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule